// File: doc/BRIEF.md
# Periodic Wake-up Timer

This block raises a wake-up interrupt request at a fixed, programmable interval. It advances on a one-cycle tick strobe that comes from an always-on slow clock, so it keeps counting while the rest of the chip is asleep. Its only on/off control is its own interrupt-enable input. While that input is low, the count is held at zero, so every new enable starts a full interval.

A 3-bit interval select scales a base period by powers of two: the interval is `BASE << sel` ticks. A change to the select takes effect at the next period boundary, and the period already under way runs to its end. At each expiry a pending flag is set, and an acknowledge pulse clears it. If an expiry arrives while the previous request is still unacknowledged, the flag stays set and an overrun flag is raised.

The block has no suspend input and no global interrupt-enable input, so neither of them can affect it. Both outputs are registered.

Top module: `wake_pacer`

## Requirements
- R1: After reset, `irq_pend` and `irq_overrun` are 0 and the active interval select is 0, so that the first period after enabling is `BASE` ticks if `sel` is 0.
- R2: The count advances only on cycles where `wake_en` and `tick_en` are both 1. With `wake_en` at 0, or with no ticks, no request is ever raised.
- R3: While the timer is enabled, `irq_pend` becomes 1 on the clock edge that samples the (`BASE << s`)-th counted tick of a period, where `s` is the select latched for that period. Requests repeat every period for as long as `wake_en` stays 1.
- R4: Any cycle with `wake_en` at 0 clears the count and loads the select, so the first request after a re-enable needs a full interval of ticks.
- R5: A change of `sel` while the timer is counting takes effect only from the next period. The current period keeps the length it started with.
- R6: An `irq_ack` pulse on a cycle without an expiry clears both `irq_pend` and `irq_overrun`.
- R7: An expiry while `irq_pend` is 1 and `irq_ack` is 0 keeps `irq_pend` at 1 and sets `irq_overrun` to 1.
- R8: An expiry on the same cycle as `irq_ack` leaves `irq_pend` at 1 and does not set `irq_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle slow tick strobe |
| wake_en | input | 1 | Timer interrupt enable; low stops and clears the timer |
| sel | input | 3 | Interval select; the interval is `BASE << sel` ticks |
| irq_ack | input | 1 | Acknowledge pulse for the pending request |
| irq_pend | output | 1 | Pending wake-up request |
| irq_overrun | output | 1 | A request expired again before it was acknowledged |

## Verification
The bench builds the timer with `BASE` set to 3. This gives periods from 3 to 384 ticks that are not powers of two, so a counter that is off by one or wraps early shows up. It also keeps even the longest setting short enough that random runs reach every select value many times, including overruns and re-enables in the middle of a period. Directed sequences set up the exact tick counts around an expiry, the coincidence of an expiry with an acknowledge, and a select change in the middle of a period.

// File: rtl/wake_pacer.sv
module wake_pacer #(
  parameter int BASE   = 4,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wake_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             irq_ack,
  output logic             irq_pend,
  output logic             irq_overrun
);
  localparam int MAXP = BASE << ((1 << SEL_W) - 1);
  localparam int CW   = $clog2(MAXP) + 1;

  logic [CW-1:0]    cnt;
  logic [SEL_W-1:0] cur_sel;
  logic [CW-1:0]    per;
  logic             expire;

  assign per    = CW'(BASE) << cur_sel;
  assign expire = wake_en && tick_en && (cnt == per - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_sel <= '0;
    end else if (!wake_en) begin
      cnt     <= '0;
      cur_sel <= sel;
    end else if (tick_en) begin
      if (expire) begin
        cnt     <= '0;
        cur_sel <= sel;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend    <= 1'b0;
      irq_overrun <= 1'b0;
    end else if (expire) begin
      irq_pend <= 1'b1;
      if (irq_pend && !irq_ack) irq_overrun <= 1'b1;
    end else if (irq_ack) begin
      irq_pend    <= 1'b0;
      irq_overrun <= 1'b0;
    end
  end

  // R2: no tick while enabled leaves the count untouched
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && !tick_en) |=> $stable(cnt));

  // R3: the count never reaches the period length
  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per);

  // R5: the latched select moves only while disabled or at a boundary
  a_r5_sel_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en && !expire |=> $stable(cur_sel));

  // R6: an acknowledge without expiry clears both flags
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !expire) |=> (!irq_pend && !irq_overrun));

  // R7: overrun can only rise while a request was already pending
  a_r7_overrun_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_overrun) |-> $past(irq_pend));

  // R8: an expiry always leaves a request pending
  a_r8_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_pend);
endmodule

// File: tb/wake_pacer_tb_top.sv
module wake_pacer_tb_top;
  localparam int BASE = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wake_en = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       irq_ack = 1'b0;
  logic       irq_pend;
  logic       irq_overrun;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  int         m_cnt = 0;
  int         m_sel = 0;
  bit         m_pend = 0;
  bit         m_ovr = 0;

  always #4 clk = ~clk;

  wake_pacer #(.BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wake_en(wake_en),
    .sel(sel), .irq_ack(irq_ack), .irq_pend(irq_pend), .irq_overrun(irq_overrun)
  );

  function automatic int period_of(input int s);
    return BASE << s;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic model(input bit e, input bit t, input int s, input bit a);
    bit hit;
    hit = 0;
    if (!e) begin
      m_cnt = 0;
      m_sel = s;
    end else if (t) begin
      if (m_cnt == period_of(m_sel) - 1) begin
        hit = 1;
        m_cnt = 0;
        m_sel = s;
      end else begin
        m_cnt++;
      end
    end
    if (hit) begin
      if (m_pend && !a) m_ovr = 1;
      m_pend = 1;
    end else if (a) begin
      m_pend = 0;
      m_ovr = 0;
    end
  endtask

  task automatic step(input bit e, input bit t, input bit [2:0] s, input bit a);
    @(negedge clk);
    wake_en = e; tick_en = t; sel = s; irq_ack = a;
    @(posedge clk);
    model(e, t, int'(s), a);
    #2;
    chk("R3 model pend", irq_pend, m_pend);
    chk("R7 model overrun", irq_overrun, m_ovr);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset pend", irq_pend, 1'b0);
    chk("R1 reset overrun", irq_overrun, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: first period of BASE ticks with select 0
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    chk("R3 before expiry", irq_pend, 1'b0);
    step(1, 1, 0, 0);
    chk("R1 first period BASE", irq_pend, 1'b1);
    step(1, 0, 0, 1);
    chk("R6 ack clears", irq_pend, 1'b0);

    // R5: select change mid-period applies next period
    step(1, 1, 0, 0);
    step(1, 1, 2, 0);
    step(1, 1, 2, 0);
    chk("R5 old length kept", irq_pend, 1'b1);
    step(1, 0, 2, 1);
    for (int i = 0; i < 11; i++) step(1, 1, 2, 0);
    chk("R5 new length not yet", irq_pend, 1'b0);
    step(1, 1, 2, 0);
    chk("R5 new length expiry", irq_pend, 1'b1);

    // R7: second expiry without ack
    for (int i = 0; i < 12; i++) step(1, 1, 2, 0);
    chk("R7 overrun set", irq_overrun, 1'b1);
    chk("R7 pend stays", irq_pend, 1'b1);
    step(1, 0, 2, 1);
    chk("R6 ack clears overrun", irq_overrun, 1'b0);
    chk("R6 ack clears pend", irq_pend, 1'b0);

    // R4: disable mid-period restarts a full interval
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0);
    step(0, 1, 0, 0);
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    chk("R4 no partial period", irq_pend, 1'b0);
    step(1, 1, 0, 0);
    chk("R4 full period after re-enable", irq_pend, 1'b1);
    step(1, 0, 0, 1);

    // R2: no progress while disabled or without ticks
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0);
    chk("R2 disabled no request", irq_pend, 1'b0);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0);
    chk("R2 no tick no request", irq_pend, 1'b0);

    // R8: expiry coincident with ack
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0);
    chk("R8 setup pend", irq_pend, 1'b1);
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    step(1, 1, 0, 1);
    chk("R8 pend kept", irq_pend, 1'b1);
    chk("R8 no overrun", irq_overrun, 1'b0);

    // random phase against the bench model
    for (int i = 0; i < 30000; i++) begin
      bit e, t, a;
      bit [2:0] s;
      e = ($urandom_range(0, 399) != 0) ? wake_en : ~wake_en;
      s = ($urandom_range(0, 299) == 0) ? 3'($urandom_range(0, 7)) : sel;
      t = ($urandom_range(0, 2) != 0);
      a = ($urandom_range(0, 59) == 0);
      step(e, t, s, a);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule